// File: doc/BRIEF.md
# Folded Shift-Add Multiplier

This block computes the unsigned product of two operands (32 bits each by default) over a sequence of clock cycles. It does not build a chain of adders. A single adder, one bit wider than the operand, handles one partial-product step per cycle. An accumulator keeps the upper half of the running sum, and the lower half of the product is collected one bit per step.

A one-cycle `start` pulse captures both operands, clears the accumulator and launches the sequence. The multiplier operand shifts right so that its next bit always sits at bit 0, and no variable-index multiplexer is needed to select it. The low product word fills from the top, also by a right shift. An iteration counter equal to the operand width means the block is idle and the result is valid. `done` reflects that state directly.

The operands carry no valid/ready handshake, so there is no back-pressure. `start` is accepted in any cycle. A start while a computation is running abandons that computation and begins again with the new operands. The product stays on `prod_hi`/`prod_lo` for as long as `done` stays high and no new start arrives.

Top module: `fold_mul`

## Requirements
- R1: After reset, `done` is 1 and `prod_hi` and `prod_lo` are both 0.
- R2: In the cycle after a clock edge that samples `start`=1, `done` is 0 and `prod_hi` is 0, because the accumulator is cleared.
- R3: `done` returns to 1 exactly WIDTH (32) clock edges after the edge that sampled `start`, provided no further start arrives in between.
- R4: When `done` rises, {`prod_hi`,`prod_lo`} equals the full 2×WIDTH-bit unsigned product of the operands captured at the start. `prod_hi` is the upper word and `prod_lo` is the lower word.
- R5: While `done` is 1 and `start` is 0, `done`, `prod_hi` and `prod_lo` do not change, whatever values `op_a` and `op_b` carry.
- R6: A start received while `done` is 0 restarts the computation with the new operands. The abandoned computation produces no `done` pulse, and R3 timing is counted from the new start.
- R7: A start may be given in the first cycle in which `done` is 1 (back-to-back operation), and the next result obeys R3 and R4.
- R8: Extreme operands give exact results: zero times any value is 0, and all-ones times all-ones gives 0xFFFFFFFE00000001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture operands and begin a multiplication |
| op_a | input | WIDTH | Multiplier operand, consumed from bit 0 upward |
| op_b | input | WIDTH | Multiplicand operand |
| done | output | 1 | High when idle, which means the product is valid |
| prod_hi | output | WIDTH | Upper word of the product |
| prod_lo | output | WIDTH | Lower word of the product |

## Verification
Two functions can collide in one cycle: loading new operands and performing a step of a running computation. Either can also coincide with the completion edge. The bench provokes each case in turn. It restarts a run partway through, restarts it one edge before the run would finish, and issues a new start in the very cycle `done` first reads high. A scoreboard holds only the product of the run that is meant to complete. The bench judges the result by requiring exactly one `done` rise per expected item, with the right product and a latency of 32 edges measured from the last start.

// File: rtl/fold_mul_pkg.sv
package fold_mul_pkg;

  // Counter width able to hold the value WIDTH itself (idle marker).
  function automatic int cnt_bits(input int width);
    return $clog2(width) + 1;
  endfunction

endpackage

// File: rtl/fold_mul_add.sv
module fold_mul_add #(
  parameter int WIDTH = 32
) (
  input  logic             sel_bit,
  input  logic [WIDTH-1:0] mcand,
  input  logic [WIDTH-1:0] acc,
  output logic [WIDTH:0]   sum
);

  logic [WIDTH-1:0] term;

  // Partial term: multiplicand when the current multiplier bit is set.
  always_comb begin
    term = sel_bit ? mcand : '0;
    sum  = {1'b0, term} + {1'b0, acc};
  end

endmodule

// File: rtl/fold_mul_ctrl.sv
module fold_mul_ctrl
  import fold_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic done
);

  localparam int CW = cnt_bits(WIDTH);
  localparam logic [CW-1:0] LAST = CW'(WIDTH);

  logic [CW-1:0] iter_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iter_q <= LAST;
    end else if (start) begin
      iter_q <= '0;
    end else if (iter_q < LAST) begin
      iter_q <= iter_q + CW'(1);
    end
  end

  // Load has priority over a step of the running computation.
  assign load = start;
  assign step = !start && (iter_q < LAST);
  assign done = (iter_q == LAST);

  assert_iter_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    iter_q <= LAST);

  assert_start_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (iter_q == '0) && !done);

  assert_iter_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && iter_q < LAST) |=> iter_q == $past(iter_q) + CW'(1));

  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !done) |=> !done);

endmodule

// File: rtl/fold_mul_dp.sv
module fold_mul_dp #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic [WIDTH-1:0] hi_word,
  output logic [WIDTH-1:0] lo_word
);

  logic [WIDTH-1:0] mplier_q;
  logic [WIDTH-1:0] mcand_q;
  logic [WIDTH-1:0] acc_q;
  logic [WIDTH-1:0] low_q;
  logic [WIDTH:0]   sum;

  fold_mul_add #(.WIDTH(WIDTH)) u_add (
    .sel_bit (mplier_q[0]),
    .mcand   (mcand_q),
    .acc     (acc_q),
    .sum     (sum)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mplier_q <= '0;
      mcand_q  <= '0;
      acc_q    <= '0;
      low_q    <= '0;
    end else if (load) begin
      mplier_q <= op_a;
      mcand_q  <= op_b;
      acc_q    <= '0;
    end else if (step) begin
      mplier_q <= mplier_q >> 1;
      acc_q    <= sum[WIDTH:1];
      low_q    <= {sum[0], low_q[WIDTH-1:1]};
    end
  end

  assign hi_word = acc_q;
  assign lo_word = low_q;

  assert_mcand_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(mcand_q));

endmodule

// File: rtl/fold_mul.sv
module fold_mul #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic             done,
  output logic [WIDTH-1:0] prod_hi,
  output logic [WIDTH-1:0] prod_lo
);

  logic load;
  logic step;

  fold_mul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .load  (load),
    .step  (step),
    .done  (done)
  );

  fold_mul_dp #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .step    (step),
    .op_a    (op_a),
    .op_b    (op_b),
    .hi_word (prod_hi),
    .lo_word (prod_lo)
  );

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done && $stable(prod_hi) && $stable(prod_lo));

  assert_clear_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> prod_hi == '0);

  assert_no_step_when_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !start && done |=> !step);

endmodule

// File: tb/test_fold_mul.sv
`timescale 1ns/1ps
module test_fold_mul;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic done;
  logic [W-1:0] prod_hi, prod_lo;

  int checks = 0;
  int errors = 0;
  int lat = 0;
  logic [2*W-1:0] exp_q[$];

  always #2 clk = ~clk;

  fold_mul #(.WIDTH(W)) i_fold_mul (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .done(done), .prod_hi(prod_hi), .prod_lo(prod_lo)
  );

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Edges since the last sampled start.
  always @(posedge clk) begin
    if (start) lat <= 0;
    else if (lat < 100000) lat <= lat + 1;
  end

  // Monitor: one scoreboard pop per done rise (R3, R4).
  initial begin
    logic prev;
    logic [63:0] e;
    prev = 1'b1;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (done && !prev) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected done", {prod_hi, prod_lo}, 64'h0);
        end else begin
          e = exp_q.pop_front();
          check({prod_hi, prod_lo} == e, "R4 product", {prod_hi, prod_lo}, e);
          check(lat == 32, "R3 latency", 64'(lat), 64'd32);
        end
      end
      prev = done;
    end
  end

  // Called at a negedge; drives start for one cycle.
  task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b, input bit push);
    op_a  = a;
    op_b  = b;
    start = 1'b1;
    if (push) exp_q.push_back({32'h0, a} * {32'h0, b});
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R2 done low after start", 64'(done), 64'h0);
    check(prod_hi == '0, "R2 accumulator cleared", 64'(prod_hi), 64'h0);
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  initial begin
    logic [W-1:0] hold_hi, hold_lo;
    repeat (3) @(negedge clk);
    check(done == 1'b1, "R1 done in reset", 64'(done), 64'h1);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b1, "R1 done after reset", 64'(done), 64'h1);
    check({prod_hi, prod_lo} == 64'h0, "R1 product zero", {prod_hi, prod_lo}, 64'h0);

    // R4 basic, R7 back-to-back (each issue follows wait_done directly)
    issue(32'd3, 32'd5, 1'b1);              wait_done();
    issue(32'h12345678, 32'h9abcdef0, 1'b1); wait_done();
    // R8 extremes
    issue(32'h0, 32'hffffffff, 1'b1);        wait_done();
    issue(32'hffffffff, 32'hffffffff, 1'b1); wait_done();
    check({prod_hi, prod_lo} == 64'hfffffffe00000001, "R8 all ones",
          {prod_hi, prod_lo}, 64'hfffffffe00000001);
    issue(32'hffffffff, 32'h0, 1'b1);        wait_done();
    check({prod_hi, prod_lo} == 64'h0, "R8 zero", {prod_hi, prod_lo}, 64'h0);
    issue(32'h80000000, 32'h80000000, 1'b1); wait_done();
    issue(32'h1, 32'h80000000, 1'b1);        wait_done();
    for (int k = 0; k < 6; k++) begin
      issue(32'hdeadbeef ^ (32'h01234567 * k), 32'hc0ffee11 + 32'(k * 977), 1'b1);
      wait_done();
    end

    // R5 idle hold while operands move
    @(negedge clk);
    hold_hi = prod_hi;
    hold_lo = prod_lo;
    for (int k = 0; k < 20; k++) begin
      op_a = 32'(k * 31337);
      op_b = ~32'(k * 7);
      @(negedge clk);
    end
    check(done == 1'b1, "R5 done held", 64'(done), 64'h1);
    check({prod_hi, prod_lo} == {hold_hi, hold_lo}, "R5 product held",
          {prod_hi, prod_lo}, {hold_hi, hold_lo});

    // R6 restart mid-run
    issue(32'haaaaaaaa, 32'h55555555, 1'b0);
    repeat (10) @(negedge clk);
    check(done == 1'b0, "R6 busy before restart", 64'(done), 64'h0);
    issue(32'h0000ffff, 32'h00010001, 1'b1);
    wait_done();
    // R6 restart one edge before completion
    issue(32'h13579bdf, 32'h2468ace0, 1'b0);
    repeat (30) @(negedge clk);
    issue(32'hfedcba98, 32'h76543210, 1'b1);
    wait_done();

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R4 all results delivered", 64'(exp_q.size()), 64'h0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R3 watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule